// File: doc/BRIEF.md
# Burst-Stepped Conversion Sequencer

This block orders the conversions of a multi-channel analog-to-digital converter over a programmable routine list. The list holds up to sixteen channel numbers. A length field gives the number of valid entries, and a burst field gives the number of channels converted per trigger. Each accepted software or external trigger starts a short burst: the block requests conversions of the next few channels of the list, one at a time, and then goes idle until the next trigger.

Successive triggers walk through the list. A burst never runs past the last valid entry. When the final entry has been converted, the block raises an end-of-sequence flag and the position returns to the start of the list. The flag can drive an interrupt line through an enable, and software clears it with a clear strobe.

The converter itself sits outside the block and is reached through a request/done handshake.

Top module: `burst_scan_sequencer`

## Requirements
- R1: An accepted trigger starts a burst of burst_m1+1 conversions (1 to 8), unless the burst is cut short by R3.
- R2: Channel slot i of the list is chan_list bits [5i+4:5i]. A burst starts at the current list position and issues channels in ascending slot order, continuing from where the previous burst stopped.
- R3: The list holds list_len_m1+1 valid entries (1 to 16). A burst that reaches the final entry stops after converting it, and the next burst starts at slot 0.
- R4: eos_flag rises one clock after the done of the final entry's conversion, and only then. It is therefore set once per full pass through the list.
- R5: irq is high exactly while eos_flag is 1 and eoc_ie is 1.
- R6: A one-cycle pulse on eos_clr clears eos_flag on the next clock. If a new set happens in the same cycle, the set wins.
- R7: A trigger (sw_trig or ext_trig high on a clock edge) that arrives while busy is 1 is ignored. It does not lengthen the burst or queue a new one.
- R8: conv_req stays high with conv_chan unchanged until conv_done is seen. The next channel is presented only in the cycle after a done.
- R9: While disc_en is 0, the list position is reset to slot 0, triggers are ignored and conv_req stays low.
- R10: After reset, conv_req, busy, eos_flag and irq are 0 and the position is slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| disc_en | input | 1 | Burst-mode enable; when low, the position is held at slot 0 |
| list_len_m1 | input | 4 | Number of valid list entries minus one |
| burst_m1 | input | 3 | Channels per burst minus one |
| chan_list | input | 80 | Sixteen 5-bit channel numbers, slot 0 in the low bits |
| sw_trig | input | 1 | Software trigger |
| ext_trig | input | 1 | External trigger |
| conv_done | input | 1 | Converter reports that the requested conversion is complete |
| eos_clr | input | 1 | Clear strobe for the end-of-sequence flag |
| eoc_ie | input | 1 | Interrupt enable |
| conv_req | output | 1 | Conversion request |
| conv_chan | output | 5 | Channel number of the current request |
| busy | output | 1 | A burst is in progress |
| eos_flag | output | 1 | End-of-sequence flag |
| irq | output | 1 | Interrupt request |

## Verification
The list walk is tried with a set of length and burst combinations:
- a burst that divides the list length exactly;
- a burst that leaves a short tail;
- a burst longer than the whole list;
- a single-entry list;
- partial passes that never reach the end.

Together these separate correct truncation at the last entry from wrap-around overshoot, and they separate once-per-pass flagging from once-per-burst flagging. Each case uses a fresh start at slot 0, and the channel sequence is compared against a model of the list.

Directed cases then cover the remaining behaviour:
- alternating software and external triggers;
- a trigger sent into a running burst;
- clearing the enable halfway through a pass, which must restart the walk at slot 0;
- the flag clear and the interrupt gate.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_CONV = 1'b1
    } seq_state_e;
endpackage

// File: rtl/seq_trig_gate.sv
module seq_trig_gate (
    input  logic sw_trig,
    input  logic ext_trig,
    input  logic enable,
    input  logic idle,
    output logic accept
);
    // Triggers are accepted only when enabled and no burst is running.
    always_comb begin
        accept = (sw_trig | ext_trig) & enable & idle;
    end
endmodule

// File: rtl/seq_slot_mux.sv
module seq_slot_mux #(
    parameter int NUM_SLOTS = 16,
    parameter int CH_W      = 5,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS*CH_W-1:0] slots_flat,
    input  logic [IDX_W-1:0]          index,
    output logic [CH_W-1:0]           chan
);
    logic [CH_W-1:0] slot_arr [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_unpack
        assign slot_arr[g] = slots_flat[g*CH_W +: CH_W];
    end

    always_comb begin
        chan = slot_arr[index];
    end
endmodule

// File: rtl/seq_flag_unit.sv
module seq_flag_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    logic flag_d, flag_q;

    // A set in the same cycle as a clear takes priority.
    always_comb begin
        flag_d = flag_q;
        if (clr_evt) flag_d = 1'b0;
        if (set_evt) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
    assign irq  = flag_q & irq_en;
endmodule

// File: rtl/burst_scan_sequencer.sv
module burst_scan_sequencer #(
    parameter int NUM_SLOTS = 16,
    parameter int CH_W      = 5,
    parameter int BURST_W   = 3,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      disc_en,
    input  logic [IDX_W-1:0]          list_len_m1,
    input  logic [BURST_W-1:0]        burst_m1,
    input  logic [NUM_SLOTS*CH_W-1:0] chan_list,
    input  logic                      sw_trig,
    input  logic                      ext_trig,
    input  logic                      conv_done,
    input  logic                      eos_clr,
    input  logic                      eoc_ie,
    output logic                      conv_req,
    output logic [CH_W-1:0]           conv_chan,
    output logic                      busy,
    output logic                      eos_flag,
    output logic                      irq
);
    import burst_seq_pkg::*;

    typedef struct packed {
        seq_state_e         state;
        logic [IDX_W-1:0]   ptr;
        logic [BURST_W-1:0] cnt;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    logic      trig_ok;
    logic      last_slot;
    logic      burst_end;
    logic      eos_set;

    seq_trig_gate u_gate (
        .sw_trig (sw_trig),
        .ext_trig(ext_trig),
        .enable  (disc_en),
        .idle    (seq_q.state == SEQ_IDLE),
        .accept  (trig_ok)
    );

    seq_slot_mux #(
        .NUM_SLOTS(NUM_SLOTS),
        .CH_W     (CH_W)
    ) u_mux (
        .slots_flat(chan_list),
        .index     (seq_q.ptr),
        .chan      (conv_chan)
    );

    // A list shortened during a pass still ends at its new last entry.
    assign last_slot = (seq_q.ptr >= list_len_m1);
    assign burst_end = (seq_q.cnt == burst_m1);

    always_comb begin
        seq_d   = seq_q;
        eos_set = 1'b0;
        if (!disc_en) begin
            seq_d.state = SEQ_IDLE;
            seq_d.ptr   = '0;
            seq_d.cnt   = '0;
        end else begin
            case (seq_q.state)
                SEQ_IDLE: begin
                    if (trig_ok) begin
                        seq_d.state = SEQ_CONV;
                        seq_d.cnt   = '0;
                    end
                end
                SEQ_CONV: begin
                    if (conv_done) begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                        if (last_slot) begin
                            seq_d.ptr = '0;
                            eos_set   = 1'b1;
                        end else begin
                            seq_d.ptr = seq_q.ptr + 1'b1;
                        end
                        if (last_slot || burst_end) seq_d.state = SEQ_IDLE;
                    end
                end
                default: seq_d.state = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= SEQ_IDLE;
            seq_q.ptr   <= '0;
            seq_q.cnt   <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    seq_flag_unit u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_evt(eos_set),
        .clr_evt(eos_clr),
        .irq_en (eoc_ie),
        .flag   (eos_flag),
        .irq    (irq)
    );

    assign conv_req = (seq_q.state == SEQ_CONV);
    assign busy     = (seq_q.state == SEQ_CONV);
endmodule

// File: rtl/burst_scan_sequencer_chk.sv
module burst_scan_sequencer_chk #(
    parameter int CH_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            disc_en,
    input logic            eos_clr,
    input logic            eoc_ie,
    input logic            conv_req,
    input logic            conv_done,
    input logic [CH_W-1:0] conv_chan,
    input logic            busy,
    input logic            eos_flag,
    input logic            irq
);
    assert_hold_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && !conv_done && disc_en) |=> (conv_req && $stable(conv_chan)));

    assert_flag_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eos_flag) |-> $past(conv_req && conv_done));

    assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc_ie |-> !irq);

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eos_clr && !(conv_req && conv_done)) |=> !eos_flag);

    assert_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !disc_en |=> !conv_req);

    assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !conv_req);
endmodule

bind burst_scan_sequencer burst_scan_sequencer_chk #(.CH_W(CH_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .disc_en  (disc_en),
    .eos_clr  (eos_clr),
    .eoc_ie   (eoc_ie),
    .conv_req (conv_req),
    .conv_done(conv_done),
    .conv_chan(conv_chan),
    .busy     (busy),
    .eos_flag (eos_flag),
    .irq      (irq)
);

// File: tb/burst_scan_sequencer_bench.sv
`timescale 1ns/1ps
module burst_scan_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disc_en = 1'b0;
    logic [3:0]  list_len_m1 = '0;
    logic [2:0]  burst_m1 = '0;
    logic [79:0] chan_list;
    logic        sw_trig = 1'b0;
    logic        ext_trig = 1'b0;
    logic        conv_done;
    logic        eos_clr = 1'b0;
    logic        eoc_ie = 1'b0;
    logic        conv_req;
    logic [4:0]  conv_chan;
    logic        busy;
    logic        eos_flag;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    burst_scan_sequencer u_burst_scan_sequencer (
        .clk(clk), .rst_n(rst_n), .disc_en(disc_en), .list_len_m1(list_len_m1),
        .burst_m1(burst_m1), .chan_list(chan_list), .sw_trig(sw_trig),
        .ext_trig(ext_trig), .conv_done(conv_done), .eos_clr(eos_clr),
        .eoc_ie(eoc_ie), .conv_req(conv_req), .conv_chan(conv_chan),
        .busy(busy), .eos_flag(eos_flag), .irq(irq)
    );

    function automatic int slot_chan(int i);
        return (i * 7 + 3) % 18;
    endfunction

    initial begin
        for (int i = 0; i < 16; i++) chan_list[i*5 +: 5] = 5'(slot_chan(i));
    end

    // Converter stub: three cycles of request before a one-cycle done.
    logic [1:0] stub_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stub_cnt  <= '0;
            conv_done <= 1'b0;
        end else if (conv_done) begin
            conv_done <= 1'b0;
            stub_cnt  <= '0;
        end else if (conv_req) begin
            if (stub_cnt == 2'd2) conv_done <= 1'b1;
            else stub_cnt <= stub_cnt + 1'b1;
        end else begin
            stub_cnt <= '0;
        end
    end

    // Log of completed conversions.
    int log_chan [256];
    int conv_total = 0;
    always @(negedge clk) begin
        if (conv_req && conv_done) begin
            log_chan[conv_total % 256] = int'(conv_chan);
            conv_total = conv_total + 1;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fire(bit use_ext);
        @(negedge clk);
        if (use_ext) ext_trig = 1'b1; else sw_trig = 1'b1;
        @(negedge clk);
        ext_trig = 1'b0;
        sw_trig  = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic restart();
        @(negedge clk);
        disc_en = 1'b0;
        eos_clr = 1'b1;
        @(negedge clk);
        eos_clr = 1'b0;
        disc_en = 1'b1;
    endtask

    // len_m1, burst_m1, triggers, expected conversions, expected flag
    localparam int NV = 6;
    localparam int VEC [NV][5] = '{
        '{6,  2, 3, 7,  1},
        '{7,  1, 3, 6,  0},
        '{15, 7, 2, 16, 1},
        '{0,  0, 2, 2,  1},
        '{4,  7, 2, 10, 1},
        '{15, 0, 4, 4,  0}
    };

    initial begin
        #4_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int start;
        int mptr;
        int ok;
        int n;
        int len;
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 conv_req", int'(conv_req), 0);
        check("R10 busy", int'(busy), 0);
        check("R10 eos_flag", int'(eos_flag), 0);
        check("R10 irq", int'(irq), 0);

        // R9: trigger with disc_en low has no effect
        fire(1'b0);
        check("R9 no conversion while disabled", conv_total, 0);

        // Table of list walks: R1 R2 R3 R4
        for (int v = 0; v < NV; v++) begin
            list_len_m1 = 4'(VEC[v][0]);
            burst_m1    = 3'(VEC[v][1]);
            restart();
            start = conv_total;
            for (int t = 0; t < VEC[v][2]; t++) fire(t[0]);
            check("R1 R3 conversion count", conv_total - start, VEC[v][3]);
            len  = VEC[v][0] + 1;
            n    = VEC[v][1] + 1;
            mptr = 0;
            ok   = 1;
            k    = start;
            for (int t = 0; t < VEC[v][2]; t++) begin
                for (int c = 0; c < n; c++) begin
                    if (log_chan[k % 256] != slot_chan(mptr)) ok = 0;
                    k++;
                    mptr++;
                    if (mptr == len) begin
                        mptr = 0;
                        break;
                    end
                end
            end
            check("R2 channel order", ok, 1);
            check("R4 flag once per pass", int'(eos_flag), VEC[v][4]);
        end

        // R5 / R6: flag, interrupt gate and clear
        list_len_m1 = 4'd2;
        burst_m1    = 3'd2;
        restart();
        fire(1'b1);
        check("R4 flag after full pass", int'(eos_flag), 1);
        check("R5 irq off when disabled", int'(irq), 0);
        eoc_ie = 1'b1;
        @(negedge clk);
        check("R5 irq on", int'(irq), 1);
        eos_clr = 1'b1;
        @(negedge clk);
        eos_clr = 1'b0;
        check("R6 flag cleared", int'(eos_flag), 0);
        check("R5 irq follows flag", int'(irq), 0);
        eoc_ie = 1'b0;

        // R7: trigger during burst ignored
        list_len_m1 = 4'd15;
        burst_m1    = 3'd2;
        restart();
        start = conv_total;
        @(negedge clk);
        sw_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
        @(negedge clk);
        ext_trig = 1'b1;
        @(negedge clk);
        ext_trig = 1'b0;
        while (busy) @(negedge clk);
        repeat (6) @(negedge clk);
        check("R7 extra trigger ignored", conv_total - start, 3);
        check("R7 idle after burst", int'(busy), 0);

        // R8: request held with a stable channel until done
        @(negedge clk);
        sw_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
        check("R8 request up", int'(conv_req), 1);
        check("R8 channel at slot 3", int'(conv_chan), slot_chan(3));
        @(negedge clk);
        check("R8 request held", int'(conv_req), 1);
        check("R8 channel held", int'(conv_chan), slot_chan(3));
        while (busy) @(negedge clk);

        // R9: clearing the enable resets the position to slot 0
        restart();
        start = conv_total;
        fire(1'b0);
        check("R9 restart at slot 0", log_chan[start % 256], slot_chan(0));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule